// File: doc/BRIEF.md
# SMBus host register front end

This block is the byte-wide register set that software uses to drive an SMBus host controller. It decodes a 64-byte window and holds a control byte, a status byte, a target address byte, a command byte, two data bytes and a 32-byte block buffer. A separate transaction sequencer owns all bus signalling. This block gives it a one-cycle start pulse, the selected transaction kind and every operand byte. It takes back the sequencer's completion and error events, plus any bytes the sequencer read from the bus.

Software first loads the address, command and data registers. It then writes the control byte with the start bit set, and polls the status byte until the busy flag drops. One event flag then says how the transfer ended. Software clears that flag by writing a one to it. Returned data appears in the data bytes and in the block buffer.

Top module: `smbus_host_regs`

## Requirements
- R1: All registers reset to zero. A read returns control at offset 0x00, status at 0x01, target address at 0x04, command at 0x05, data0 at 0x06 and data1 at 0x07, and the block buffer at 0x20 to 0x3F. Every other offset reads as zero.
- R2: Control bits 2:0 hold the transaction kind, which drives seq_type. Bits 7, 5 and 3 read back as last written and have no effect. Bits 6 and 4 always read as zero. A control write without bit 4 leaves the status byte unchanged.
- R3: A control write with bit 4 set is accepted when busy is clear and bits 2:0 are 0 (quick), 1 (byte), 2 (byte data), 3 (word data) or 5 (block). On the following cycle seq_start is high for exactly one cycle and status bit 3 (busy) reads one.
- R4: A start is ignored while busy is set, including in the cycle a sequencer event arrives. A start is also ignored when bits 2:0 are 4, 6 or 7. An ignored start gives no seq_start pulse.
- R5: While busy, an event sets exactly one status bit and clears busy on the same clock edge. The bits are collision in bit 2, device error in bit 1 and completion in bit 0. When several events arrive together, collision wins over device error, and device error wins over completion.
- R6: Sequencer events that arrive while busy is clear leave the status byte unchanged.
- R7: Writing one to a status bit 0 to 2 clears that bit, and writing zero leaves it unchanged. Writes never change busy. Status bits 7:4 read as zero.
- R8: If a status bit is being set by an event in the same cycle software writes one to clear it, the bit ends up set.
- R9: The target, command, data0 and data1 registers are read/write bytes. seq_dev_addr carries target bits 7:1 and seq_rnw carries target bit 0, where 1 means read. seq_cmd, seq_data0 and seq_data1 carry the other three registers.
- R10: seq_d0_we or seq_d1_we loads seq_rdata into data0 or data1. If software writes the same register in the same cycle, the sequencer's value is kept.
- R11: Software reads and writes block byte i at offset 0x20+i. seq_blk_rdata shows the byte at seq_blk_idx. seq_blk_we writes seq_blk_wdata there, and it wins over a software write to the same byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | 6 | Register offset within the window |
| cpu_we | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for cpu_addr (combinational) |
| seq_start | output | 1 | One-cycle transaction start pulse |
| seq_type | output | 3 | Transaction kind from control bits 2:0 |
| seq_dev_addr | output | 7 | 7-bit device address |
| seq_rnw | output | 1 | Direction, 1 = read |
| seq_cmd | output | 8 | Command byte |
| seq_data0 | output | 8 | Data byte 0 / block count |
| seq_data1 | output | 8 | Data byte 1 |
| seq_blk_idx | input | 5 | Block buffer index used by the sequencer |
| seq_blk_rdata | output | 8 | Block byte at seq_blk_idx |
| seq_blk_we | input | 1 | Sequencer block buffer write |
| seq_blk_wdata | input | 8 | Sequencer block buffer write data |
| seq_d0_we | input | 1 | Sequencer load of data0 |
| seq_d1_we | input | 1 | Sequencer load of data1 |
| seq_rdata | input | 8 | Byte returned by the sequencer |
| seq_done | input | 1 | Transaction completed |
| seq_dev_err | input | 1 | Device gave no response |
| seq_collision | input | 1 | Bus collision |

## Verification
Two writers can land on the same state in the same cycle. One case is a sequencer event against a software write-one-to-clear of the status byte. The other is the sequencer returning a byte into data0, data1 or the block buffer while software writes that same location. The bench provokes both by driving the event or the sequencer write strobe in the same cycle as the software write. It then judges the result by reading the register back through the normal port: the set bit or the sequencer's byte must survive, while unrelated event bits cleared by the same write must be gone. A start write that falls in the same cycle as an ending event is provoked the same way, and it must produce no start pulse.

// File: rtl/smbh_pkg.sv
package smbh_pkg;

    localparam int WIN_AW = 6;
    localparam int BYTE_W = 8;

    localparam logic [WIN_AW-1:0] OFS_CTRL  = 6'h00;
    localparam logic [WIN_AW-1:0] OFS_STS   = 6'h01;
    localparam logic [WIN_AW-1:0] OFS_TADDR = 6'h04;
    localparam logic [WIN_AW-1:0] OFS_CMD   = 6'h05;
    localparam logic [WIN_AW-1:0] OFS_D0    = 6'h06;
    localparam logic [WIN_AW-1:0] OFS_D1    = 6'h07;

    typedef struct packed {
        logic       keep7;
        logic       keep5;
        logic       keep3;
        logic [2:0] kind;
    } ctrl_t;

    // bit order matches the status byte: busy=3, collide=2, dev_err=1, done=0
    typedef struct packed {
        logic busy;
        logic collide;
        logic dev_err;
        logic done;
    } sts_t;

    typedef struct packed {
        logic ctrl;
        logic sts;
        logic taddr;
        logic cmd;
        logic d0;
        logic d1;
        logic blk;
    } sel_t;

    function automatic logic kind_ok(input logic [2:0] k);
        return (k == 3'd0) || (k == 3'd1) || (k == 3'd2) ||
               (k == 3'd3) || (k == 3'd5);
    endfunction

    function automatic logic [2:0] evt_pick(input logic done, input logic err,
                                            input logic col);
        if (col)       return 3'b100;
        else if (err)  return 3'b010;
        else if (done) return 3'b001;
        else           return 3'b000;
    endfunction

    function automatic sel_t win_decode(input logic [WIN_AW-1:0] a);
        sel_t s;
        s       = '0;
        s.ctrl  = (a == OFS_CTRL);
        s.sts   = (a == OFS_STS);
        s.taddr = (a == OFS_TADDR);
        s.cmd   = (a == OFS_CMD);
        s.d0    = (a == OFS_D0);
        s.d1    = (a == OFS_D1);
        s.blk   = a[WIN_AW-1];
        return s;
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_byte(input ctrl_t c);
        return {c.keep7, 1'b0, c.keep5, 1'b0, c.keep3, c.kind};
    endfunction

endpackage

// File: rtl/smbh_ctrl_status.sv
module smbh_ctrl_status
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic              wr_sts,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              ev_done,
    input  logic              ev_err,
    input  logic              ev_col,
    output ctrl_t             ctrl_q,
    output sts_t              sts_q,
    output logic              start_q
);

    logic       start_ok;
    logic       ev_live;
    logic [2:0] ev_new;
    logic [2:0] ev_clr;
    logic [2:0] ev_next;
    logic       unused_bit6;

    assign unused_bit6 = wdata[6];

    always_comb begin
        start_ok = wr_ctrl && wdata[4] && !sts_q.busy && kind_ok(wdata[2:0]);
        ev_live  = sts_q.busy && (ev_done || ev_err || ev_col);
        ev_new   = ev_live ? evt_pick(ev_done, ev_err, ev_col) : 3'b000;
        ev_clr   = wr_sts ? wdata[2:0] : 3'b000;
        ev_next  = ({sts_q.collide, sts_q.dev_err, sts_q.done} & ~ev_clr) | ev_new;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            sts_q   <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= start_ok;
            if (wr_ctrl) begin
                ctrl_q.keep7 <= wdata[7];
                ctrl_q.keep5 <= wdata[5];
                ctrl_q.keep3 <= wdata[3];
                ctrl_q.kind  <= wdata[2:0];
            end
            sts_q.collide <= ev_next[2];
            sts_q.dev_err <= ev_next[1];
            sts_q.done    <= ev_next[0];
            if (ev_live)
                sts_q.busy <= 1'b0;
            else if (start_ok)
                sts_q.busy <= 1'b1;
        end
    end

    // R3: the start pulse lasts a single cycle
    p_pulse_single_r3: assert property (@(posedge clk) disable iff (rst)
        start_q |=> !start_q);

    // R3: busy only rises together with a start pulse
    p_busy_with_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(sts_q.busy) |-> start_q);

    // R4: a start written while busy never pulses
    p_restart_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        (sts_q.busy && wr_ctrl && wdata[4]) |=> !start_q);

    // R5: an event while busy ends the transfer with an event flag set
    p_event_ends_r5: assert property (@(posedge clk) disable iff (rst)
        (sts_q.busy && (ev_done || ev_err || ev_col)) |=>
            (!sts_q.busy && (sts_q.collide || sts_q.dev_err || sts_q.done)));

    // R6: idle events leave the flags alone
    p_idle_event_r6: assert property (@(posedge clk) disable iff (rst)
        (!sts_q.busy && !wr_sts && (ev_done || ev_err || ev_col)) |=>
            $stable({sts_q.collide, sts_q.dev_err, sts_q.done}));

    // R7: write-one clears completion when no event competes
    p_w1c_done_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_sts && wdata[0] && !(sts_q.busy && (ev_done || ev_err || ev_col)))
            |=> !sts_q.done);

    // R8: a collision event beats a simultaneous clear
    p_set_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (sts_q.busy && ev_col) |=> sts_q.collide);

endmodule

// File: rtl/smbh_operands.sv
module smbh_operands
    import smbh_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_taddr,
    input  logic              wr_cmd,
    input  logic              wr_d0,
    input  logic              wr_d1,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              seq_d0_we,
    input  logic              seq_d1_we,
    input  logic [BYTE_W-1:0] seq_rdata,
    output logic [BYTE_W-1:0] taddr_q,
    output logic [BYTE_W-1:0] cmd_q,
    output logic [BYTE_W-1:0] d0_q,
    output logic [BYTE_W-1:0] d1_q
);

    localparam int NREG = 4;

    logic [NREG-1:0]   cpu_we;
    logic [NREG-1:0]   seq_we;
    logic [BYTE_W-1:0] opr [NREG];

    assign cpu_we = {wr_d1, wr_d0, wr_cmd, wr_taddr};
    assign seq_we = {seq_d1_we, seq_d0_we, 2'b00};

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (seq_we[g])
                q <= seq_rdata;
            else if (cpu_we[g])
                q <= wdata;
        end
        assign opr[g] = q;
    end

    assign taddr_q = opr[0];
    assign cmd_q   = opr[1];
    assign d0_q    = opr[2];
    assign d1_q    = opr[3];

    // R10: a sequencer load of data0 lands regardless of a software write
    p_seq_d0_wins_r10: assert property (@(posedge clk) disable iff (rst)
        seq_d0_we |=> (d0_q == $past(seq_rdata)));

    p_seq_d1_wins_r10: assert property (@(posedge clk) disable iff (rst)
        seq_d1_we |=> (d1_q == $past(seq_rdata)));

endmodule

// File: rtl/smbh_blkbuf.sv
module smbh_blkbuf
    import smbh_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_we,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [BYTE_W-1:0] cpu_wdata,
    output logic [BYTE_W-1:0] cpu_rdata,
    input  logic              seq_we,
    input  logic [IDX_W-1:0]  seq_idx,
    input  logic [BYTE_W-1:0] seq_wdata,
    output logic [BYTE_W-1:0] seq_rdata
);

    logic [BYTE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] <= '0;
        end else begin
            if (cpu_we)
                mem[cpu_idx] <= cpu_wdata;
            if (seq_we)
                mem[seq_idx] <= seq_wdata;
        end
    end

    assign cpu_rdata = mem[cpu_idx];
    assign seq_rdata = mem[seq_idx];

    // R11: the sequencer's byte is what the sequencer port shows next cycle
    p_seq_write_r11: assert property (@(posedge clk) disable iff (rst)
        (seq_we && $stable(seq_idx)) |=> (seq_rdata == $past(seq_wdata) || seq_we
            || seq_idx != $past(seq_idx)));

endmodule

// File: rtl/smbus_host_regs.sv
module smbus_host_regs
    import smbh_pkg::*;
#(
    parameter int BLK_DEPTH = 32,
    localparam int IDX_W = $clog2(BLK_DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [5:0]       cpu_addr,
    input  logic             cpu_we,
    input  logic [7:0]       cpu_wdata,
    output logic [7:0]       cpu_rdata,
    output logic             seq_start,
    output logic [2:0]       seq_type,
    output logic [6:0]       seq_dev_addr,
    output logic             seq_rnw,
    output logic [7:0]       seq_cmd,
    output logic [7:0]       seq_data0,
    output logic [7:0]       seq_data1,
    input  logic [IDX_W-1:0] seq_blk_idx,
    output logic [7:0]       seq_blk_rdata,
    input  logic             seq_blk_we,
    input  logic [7:0]       seq_blk_wdata,
    input  logic             seq_d0_we,
    input  logic             seq_d1_we,
    input  logic [7:0]       seq_rdata,
    input  logic             seq_done,
    input  logic             seq_dev_err,
    input  logic             seq_collision
);

    sel_t              sel;
    ctrl_t             ctrl_q;
    sts_t              sts_q;
    logic [BYTE_W-1:0] taddr_q, cmd_q, d0_q, d1_q, blk_rd;

    assign sel = win_decode(cpu_addr);

    smbh_ctrl_status u_cs (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (cpu_we && sel.ctrl),
        .wr_sts  (cpu_we && sel.sts),
        .wdata   (cpu_wdata),
        .ev_done (seq_done),
        .ev_err  (seq_dev_err),
        .ev_col  (seq_collision),
        .ctrl_q  (ctrl_q),
        .sts_q   (sts_q),
        .start_q (seq_start)
    );

    smbh_operands u_ops (
        .clk       (clk),
        .rst       (rst),
        .wr_taddr  (cpu_we && sel.taddr),
        .wr_cmd    (cpu_we && sel.cmd),
        .wr_d0     (cpu_we && sel.d0),
        .wr_d1     (cpu_we && sel.d1),
        .wdata     (cpu_wdata),
        .seq_d0_we (seq_d0_we),
        .seq_d1_we (seq_d1_we),
        .seq_rdata (seq_rdata),
        .taddr_q   (taddr_q),
        .cmd_q     (cmd_q),
        .d0_q      (d0_q),
        .d1_q      (d1_q)
    );

    smbh_blkbuf #(.DEPTH(BLK_DEPTH)) u_blk (
        .clk       (clk),
        .rst       (rst),
        .cpu_we    (cpu_we && sel.blk),
        .cpu_idx   (cpu_addr[IDX_W-1:0]),
        .cpu_wdata (cpu_wdata),
        .cpu_rdata (blk_rd),
        .seq_we    (seq_blk_we),
        .seq_idx   (seq_blk_idx),
        .seq_wdata (seq_blk_wdata),
        .seq_rdata (seq_blk_rdata)
    );

    always_comb begin
        cpu_rdata = '0;
        if (sel.ctrl)       cpu_rdata = ctrl_byte(ctrl_q);
        else if (sel.sts)   cpu_rdata = {4'b0000, sts_q};
        else if (sel.taddr) cpu_rdata = taddr_q;
        else if (sel.cmd)   cpu_rdata = cmd_q;
        else if (sel.d0)    cpu_rdata = d0_q;
        else if (sel.d1)    cpu_rdata = d1_q;
        else if (sel.blk)   cpu_rdata = blk_rd;
    end

    assign seq_type     = ctrl_q.kind;
    assign seq_dev_addr = taddr_q[7:1];
    assign seq_rnw      = taddr_q[0];
    assign seq_cmd      = cmd_q;
    assign seq_data0    = d0_q;
    assign seq_data1    = d1_q;

    // R1: offsets outside the map read as zero
    p_hole_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (sel == '0) |-> (cpu_rdata == 8'h00));

endmodule

// File: tb/sim_smbus_host_regs.sv
module sim_smbus_host_regs;
    timeunit 1ns;
    timeprecision 100ps;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] cpu_addr = '0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = '0;
    logic [7:0] cpu_rdata;
    logic       seq_start;
    logic [2:0] seq_type;
    logic [6:0] seq_dev_addr;
    logic       seq_rnw;
    logic [7:0] seq_cmd, seq_data0, seq_data1;
    logic [4:0] seq_blk_idx = '0;
    logic [7:0] seq_blk_rdata;
    logic       seq_blk_we = 1'b0;
    logic [7:0] seq_blk_wdata = '0;
    logic       seq_d0_we = 1'b0, seq_d1_we = 1'b0;
    logic [7:0] seq_rdata = '0;
    logic       seq_done = 1'b0, seq_dev_err = 1'b0, seq_collision = 1'b0;

    int errs = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    smbus_host_regs u0 (.*);

    task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %02h expected %02h", tag, got, exp);
        end
    endtask

    // called just after a falling edge; returns just after the next one
    task automatic cyc(input bit we, input logic [5:0] a, input logic [7:0] d);
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_we = 1'b0;
        seq_done = 1'b0; seq_dev_err = 1'b0; seq_collision = 1'b0;
        seq_d0_we = 1'b0; seq_d1_we = 1'b0; seq_blk_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] v);
        cpu_addr = a;
        #1;
        v = cpu_rdata;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 37 + 11) & 255);
    endfunction

    function automatic bit kind_ok_m(input int t);
        return (t == 0) || (t == 1) || (t == 2) || (t == 3) || (t == 5);
    endfunction

    initial begin
        #1000000;
        errs++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0] r;
        logic [7:0] e;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state over the whole window
        for (int a = 0; a < 64; a++) begin
            rd(6'(a), r);
            chk("R1 reset read", r, 8'h00);
        end
        chk("R3 no pulse after reset", {7'd0, seq_start}, 8'h00);

        // R1 / R9 / R11 write sweep then read back
        for (int a = 2; a < 64; a++) cyc(1'b1, 6'(a), pat(a));
        for (int a = 0; a < 64; a++) begin
            e = ((a >= 4 && a <= 7) || a >= 32) ? pat(a) : 8'h00;
            rd(6'(a), r);
            if (a >= 32)      chk("R11 block readback", r, e);
            else if (a >= 4 && a <= 7) chk("R9 operand readback", r, e);
            else              chk("R1 map/hole read", r, e);
        end
        chk("R9 device address", {1'b0, seq_dev_addr}, pat(4) >> 1);
        chk("R9 direction bit", {7'd0, seq_rnw}, pat(4) & 8'h01);
        chk("R9 command out", seq_cmd, pat(5));
        chk("R9 data0 out", seq_data0, pat(6));
        chk("R9 data1 out", seq_data1, pat(7));
        for (int i = 0; i < 32; i++) begin
            seq_blk_idx = 5'(i);
            #1;
            chk("R11 sequencer read port", seq_blk_rdata, pat(32 + i));
        end

        // R2 control field sweep without the start bit
        for (int v = 0; v < 256; v++) begin
            if ((v & 16) == 0) begin
                cyc(1'b1, 6'h00, 8'(v));
                rd(6'h00, r);
                chk("R2 control readback", r, 8'(v) & 8'hAF);
                chk("R2 type out", {5'd0, seq_type}, 8'(v & 7));
                chk("R2 no pulse", {7'd0, seq_start}, 8'h00);
                rd(6'h01, r);
                chk("R2 status untouched", r, 8'h00);
            end
        end

        // R3 / R4 / R5 / R6 per kind and per event
        for (int t = 0; t < 8; t++) begin
            for (int ev = 0; ev < 3; ev++) begin
                bit ok;
                ok = kind_ok_m(t);
                cyc(1'b1, 6'h00, 8'h10 | 8'(t));
                chk(ok ? "R3 start pulse" : "R4 bad kind no pulse", {7'd0, seq_start}, {7'd0, ok});
                rd(6'h01, r);
                chk(ok ? "R3 busy set" : "R4 bad kind idle", r, ok ? 8'h08 : 8'h00);
                rd(6'h00, r);
                chk("R2 start bit reads zero", r, 8'(t));
                if (ok) begin
                    chk("R3 type forwarded", {5'd0, seq_type}, 8'(t));
                    cyc(1'b1, 6'h00, 8'h10 | 8'(t));
                    chk("R4 restart while busy", {7'd0, seq_start}, 8'h00);
                    rd(6'h01, r);
                    chk("R4 still busy", r, 8'h08);
                end
                seq_done = (ev == 0); seq_dev_err = (ev == 1); seq_collision = (ev == 2);
                cyc(1'b0, 6'h00, 8'h00);
                rd(6'h01, r);
                chk(ok ? "R5 event recorded" : "R6 idle event ignored", r,
                    ok ? 8'(1 << ev) : 8'h00);
                cyc(1'b1, 6'h01, 8'h07);
                rd(6'h01, r);
                chk("R7 clear all", r, 8'h00);
            end
        end

        // R5 priority over every event combination
        for (int m = 1; m < 8; m++) begin
            cyc(1'b1, 6'h00, 8'h11);
            seq_done = m[0]; seq_dev_err = m[1]; seq_collision = m[2];
            cyc(1'b0, 6'h00, 8'h00);
            rd(6'h01, r);
            chk("R5 priority", r, m[2] ? 8'h04 : (m[1] ? 8'h02 : 8'h01));
            cyc(1'b1, 6'h01, 8'h07);
        end

        // R7 partial clears
        cyc(1'b1, 6'h00, 8'h11);
        seq_done = 1'b1;
        cyc(1'b0, 6'h00, 8'h00);
        cyc(1'b1, 6'h01, 8'hF6);
        rd(6'h01, r);
        chk("R7 zero leaves bit", r, 8'h01);
        cyc(1'b1, 6'h00, 8'h11);
        cyc(1'b1, 6'h01, 8'h08);
        rd(6'h01, r);
        chk("R7 busy not writable", r, 8'h09);

        // R8 event against clear in the same cycle
        seq_dev_err = 1'b1;
        cyc(1'b1, 6'h01, 8'h03);
        rd(6'h01, r);
        chk("R8 clear old, set new", r, 8'h02);
        cyc(1'b1, 6'h00, 8'h11);
        seq_done = 1'b1;
        cyc(1'b1, 6'h01, 8'h01);
        rd(6'h01, r);
        chk("R8 set wins over clear", r, 8'h03);
        cyc(1'b1, 6'h01, 8'h07);

        // R4 start in the cycle the transfer ends
        cyc(1'b1, 6'h00, 8'h11);
        seq_collision = 1'b1;
        cyc(1'b1, 6'h00, 8'h11);
        chk("R4 start at event edge", {7'd0, seq_start}, 8'h00);
        rd(6'h01, r);
        chk("R4 status after event edge", r, 8'h04);
        cyc(1'b1, 6'h01, 8'h07);

        // R10 sequencer returns data
        seq_d0_we = 1'b1; seq_rdata = 8'h5A;
        cyc(1'b1, 6'h06, 8'h33);
        rd(6'h06, r);
        chk("R10 data0 sequencer wins", r, 8'h5A);
        chk("R10 data0 forwarded", seq_data0, 8'h5A);
        seq_d1_we = 1'b1; seq_rdata = 8'hA5;
        cyc(1'b0, 6'h00, 8'h00);
        rd(6'h07, r);
        chk("R10 data1 load", r, 8'hA5);
        cyc(1'b1, 6'h07, 8'h77);
        rd(6'h07, r);
        chk("R9 data1 software write", r, 8'h77);

        // R11 sequencer block writes
        seq_blk_we = 1'b1; seq_blk_idx = 5'd3; seq_blk_wdata = 8'hC3;
        cyc(1'b1, 6'h23, 8'h11);
        rd(6'h23, r);
        chk("R11 sequencer wins block byte", r, 8'hC3);
        chk("R11 sequencer port view", seq_blk_rdata, 8'hC3);
        seq_blk_we = 1'b1; seq_blk_idx = 5'd31; seq_blk_wdata = 8'h9E;
        cyc(1'b0, 6'h00, 8'h00);
        rd(6'h3F, r);
        chk("R11 last block byte", r, 8'h9E);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule